// File: doc/BRIEF.md
# Multi-Master Bus Switch Arbiter

This block decides which of several requesters may drive one shared master interface of a DMA switch. Five kinds of agent compete for it. Two bridge paths carry accesses that arrive from the primary system bus, one toward the secondary bus and one toward the serial link. Two move engines issue single read or write moves, and each move is tagged with the priority of the channel that started it. The serial link module also requests. Every target interface of the switch gets its own instance of this block.

Priority comes in layers. Bridge traffic ranks first, so that the primary bus sees as few wait states as possible. Engine writes come next, then engine reads, and link traffic ranks last. Within one layer of engine traffic, the higher channel priority wins, and an exact tie goes to the engine with the lower index. The grant is registered and one-hot. It stays with the winning agent until that agent signals the end of its transfer, and the next decision is made in the cycle after that. The block also drives the privilege mode of the outgoing access. It rejects bridge accesses that are marked read-modify-write: it returns an error pulse and gives no grant.

Top module: `bus_switch_arbiter`

## Requirements
- R1: While `rst` is high on a rising edge, the block clears `grant`, drives `bus_user` to 0 (supervisor) and clears `brg_err`, whatever the inputs are.
- R2: `grant` never has more than one bit set. When `grant` is all zero, a pending valid request is granted on the next rising edge. The bit order is: bridge paths at bits 0..NUM_BRG-1, engine k at bit NUM_BRG+k, and the link module at the top bit.
- R3: Once set, `grant` holds its value, whatever the requests do, until an edge at which `xfer_done` is high. That edge clears `grant`, and the next arbitration happens at the edge after it.
- R4: A valid bridge request beats every engine and link request. Bridge 0 (toward the secondary bus) beats bridge 1 (toward the link interface).
- R5: Among engine requests, a write (`eng_wr`=1) beats a read, whatever the channel priorities are.
- R6: When engines request in the same direction, the one whose `eng_prio` field (PRIO_W bits per engine, engine k at bits k*PRIO_W upward, a larger value meaning higher priority) is greater wins. On equal priority, the lower engine index wins.
- R7: The link module is granted only when no bridge request and no engine request is valid.
- R8: While a bridge holds the grant, `bus_user` equals that bridge's `brg_user` bit as it was sampled at the granting edge. The value is held for the whole grant.
- R9: `bus_user` is 0 (supervisor) whenever an engine or the link module holds the grant, and whenever no grant is active.
- R10: A bridge request with its `brg_rmw` bit set is never granted. On the next edge the block sets that bridge's `brg_err` bit for the cycle, and the other requests are still arbitrated as if that request were absent.
- R11: An engine does not keep the bus across moves. After `xfer_done`, an engine that is still requesting competes again and can lose to a higher-ranked request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| brg_req | input | NUM_BRG | Bridge path requests (bit 0 toward secondary bus) |
| brg_rmw | input | NUM_BRG | Bridge request is a read-modify-write access |
| brg_user | input | NUM_BRG | Incoming mode of the bridge access, 1 = user |
| eng_req | input | NUM_ENG | Move engine requests, one move each |
| eng_wr | input | NUM_ENG | Direction of the engine move, 1 = write |
| eng_prio | input | NUM_ENG*PRIO_W | Priority of each engine's active channel |
| lnk_req | input | 1 | Link module request |
| xfer_done | input | 1 | Granted agent finishes its transfer this cycle |
| grant | output | NUM_BRG+NUM_ENG+1 | One-hot registered grant |
| bus_user | output | 1 | Mode of the outgoing access, 1 = user, 0 = supervisor |
| brg_err | output | NUM_BRG | One-cycle error response to a read-modify-write bridge request |

## Verification
The bench uses the default configuration: two bridge paths, two engines and 2-bit channel priorities. With these values the whole request space fits into 13 input bits, and the bench steps through all 8192 combinations of bridge requests, read-modify-write flags, engine requests, directions, both priority fields and the link request. It computes the expected winner, mode and error response arithmetically for each one. Each granted case is then held while every other agent raises its request and the bridge mode bits flip, which tests that the grant and mode stay fixed. A directed sequence then has a lower-priority engine keep requesting across `xfer_done`, to show that each move is arbitrated again.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic {
        MODE_SUP  = 1'b0,
        MODE_USER = 1'b1
    } bus_mode_e;

endpackage

// File: rtl/bsa_first_one.sv
module bsa_first_one #(
    parameter int W = 2
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] pick
);

    always_comb begin
        pick = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i] && (pick == '0)) begin
                pick[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsa_eng_select.sv
module bsa_eng_select #(
    parameter int NUM_ENG = 2,
    parameter int PRIO_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_ENG-1:0]         valid,
    input  logic [NUM_ENG*PRIO_W-1:0]  prio,
    output logic [NUM_ENG-1:0]         pick,
    output logic                       any
);

    localparam int PW = PRIO_W;

    logic [PW-1:0] best;
    logic          found;
    logic [PW-1:0] sel_prio;

    always_comb begin
        pick  = '0;
        best  = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (valid[i] && (!found || (prio[i*PW +: PW] > best))) begin
                pick    = '0;
                pick[i] = 1'b1;
                best    = prio[i*PW +: PW];
                found   = 1'b1;
            end
        end
    end

    assign any = |valid;

    // Priority of the picked engine, recovered from the pick vector
    always_comb begin
        sel_prio = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (pick[i]) sel_prio = prio[i*PW +: PW];
        end
    end

    for (genvar j = 0; j < NUM_ENG; j++) begin : g_chk
        AST_SEL_MAX: assert property (@(posedge clk) disable iff (rst)
            valid[j] |-> (sel_prio >= prio[j*PW +: PW])); // R6
        AST_SEL_TIE: assert property (@(posedge clk) disable iff (rst)
            (valid[j] && (prio[j*PW +: PW] == sel_prio)) |-> ((pick >> (j+1)) == '0)); // R6
    end

endmodule

// File: rtl/bus_switch_arbiter.sv
module bus_switch_arbiter
    import bsa_pkg::*;
#(
    parameter int NUM_BRG = 2,
    parameter int NUM_ENG = 2,
    parameter int PRIO_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_BRG-1:0]                brg_req,
    input  logic [NUM_BRG-1:0]                brg_rmw,
    input  logic [NUM_BRG-1:0]                brg_user,
    input  logic [NUM_ENG-1:0]                eng_req,
    input  logic [NUM_ENG-1:0]                eng_wr,
    input  logic [NUM_ENG*PRIO_W-1:0]         eng_prio,
    input  logic                              lnk_req,
    input  logic                              xfer_done,
    output logic [NUM_BRG+NUM_ENG:0]          grant,
    output logic                              bus_user,
    output logic [NUM_BRG-1:0]                brg_err
);

    localparam int NUM_AGT = NUM_BRG + NUM_ENG + 1;
    localparam int ENG_LO  = NUM_BRG;
    localparam int LNK_IDX = NUM_AGT - 1;
    localparam int NUM_DIR = 2;   // 0 = write layer, 1 = read layer

    typedef struct packed {
        logic [NUM_AGT-1:0] grant;
        bus_mode_e          mode;
        logic [NUM_BRG-1:0] err;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [NUM_BRG-1:0] brg_ok;
    logic [NUM_BRG-1:0] brg_pick;
    logic [NUM_ENG-1:0] dir_valid [NUM_DIR];
    logic [NUM_ENG-1:0] dir_pick  [NUM_DIR];
    logic               dir_any   [NUM_DIR];

    assign brg_ok = brg_req & ~brg_rmw;

    bsa_first_one #(.W(NUM_BRG)) u_brg_pick (
        .req  (brg_ok),
        .pick (brg_pick)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        assign dir_valid[d] = (d == 0) ? (eng_req & eng_wr) : (eng_req & ~eng_wr);

        bsa_eng_select #(.NUM_ENG(NUM_ENG), .PRIO_W(PRIO_W)) u_sel (
            .clk   (clk),
            .rst   (rst),
            .valid (dir_valid[d]),
            .prio  (eng_prio),
            .pick  (dir_pick[d]),
            .any   (dir_any[d])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.err = brg_req & brg_rmw;
        if (state_q.grant == '0) begin
            state_d.grant = '0;
            state_d.mode  = MODE_SUP;
            if (|brg_ok) begin
                state_d.grant[NUM_BRG-1:0] = brg_pick;
                state_d.mode = (|(brg_pick & brg_user)) ? MODE_USER : MODE_SUP;
            end else if (dir_any[0]) begin
                state_d.grant[ENG_LO +: NUM_ENG] = dir_pick[0];
            end else if (dir_any[1]) begin
                state_d.grant[ENG_LO +: NUM_ENG] = dir_pick[1];
            end else if (lnk_req) begin
                state_d.grant[LNK_IDX] = 1'b1;
            end
        end else if (xfer_done) begin
            state_d.grant = '0;
            state_d.mode  = MODE_SUP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant    = state_q.grant;
    assign bus_user = (state_q.mode == MODE_USER);
    assign brg_err  = state_q.err;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R2
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && !xfer_done) |=> $stable(grant)); // R3
    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && xfer_done) |=> (grant == '0)); // R3
    AST_BRG_FIRST: assert property (@(posedge clk) disable iff (rst)
        ((grant == '0) && |(brg_req & ~brg_rmw)) |=> |grant[NUM_BRG-1:0]); // R4
    AST_WR_OVER_RD: assert property (@(posedge clk) disable iff (rst)
        ((grant == '0) && !(|(brg_req & ~brg_rmw)) && |(eng_req & eng_wr))
        |=> |(grant[ENG_LO +: NUM_ENG] & $past(eng_req & eng_wr))); // R5
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        ((grant != '0) && !xfer_done) |=> $stable(bus_user)); // R8
    AST_SUP_NONBRG: assert property (@(posedge clk) disable iff (rst)
        (grant[LNK_IDX:ENG_LO] != '0) |-> !bus_user); // R9
    AST_SUP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |-> !bus_user); // R9

    for (genvar b = 0; b < NUM_BRG; b++) begin : g_rmw_chk
        AST_RMW_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
            ((grant == '0) && brg_req[b] && brg_rmw[b]) |=> !grant[b]); // R10
    end

endmodule

// File: tb/bus_switch_arbiter_bench.sv
module bus_switch_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] brg_req, brg_rmw, brg_user;
    logic [1:0] eng_req, eng_wr;
    logic [3:0] eng_prio;
    logic       lnk_req, xfer_done;
    logic [4:0] grant;
    logic       bus_user;
    logic [1:0] brg_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_switch_arbiter #(.NUM_BRG(2), .NUM_ENG(2), .PRIO_W(2)) u_bus_switch_arbiter (
        .clk(clk), .rst(rst),
        .brg_req(brg_req), .brg_rmw(brg_rmw), .brg_user(brg_user),
        .eng_req(eng_req), .eng_wr(eng_wr), .eng_prio(eng_prio),
        .lnk_req(lnk_req), .xfer_done(xfer_done),
        .grant(grant), .bus_user(bus_user), .brg_err(brg_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic idle_inputs();
        brg_req = '0; brg_rmw = '0; brg_user = '0;
        eng_req = '0; eng_wr = '0; eng_prio = '0;
        lnk_req = 1'b0; xfer_done = 1'b0;
    endtask

    // Expected winner from the layered ranking; tag names the deciding rule
    task automatic model(input logic [1:0] br, input logic [1:0] rm, input logic [1:0] us,
                         input logic [1:0] er, input logic [1:0] ew, input logic [3:0] pr,
                         input logic lk, output logic [4:0] g, output logic u,
                         output string tag);
        logic [1:0] ok, wv, rv, set;
        ok = br & ~rm;
        wv = er & ew;
        rv = er & ~ew;
        g = '0; u = 1'b0; tag = "R2";
        if (ok != 0) begin
            if (ok[0]) begin g = 5'b00001; u = us[0]; end
            else       begin g = 5'b00010; u = us[1]; end
            tag = (rm != 0) ? "R10" : "R4";
        end else if (er != 0) begin
            set = (wv != 0) ? wv : rv;
            if (set == 2'b11) begin
                g = (pr[3:2] > pr[1:0]) ? 5'b01000 : 5'b00100;
                tag = "R6";
            end else begin
                g = set[0] ? 5'b00100 : 5'b01000;
                tag = (wv != 0 && rv != 0) ? "R5" : "R2";
            end
        end else if (lk) begin
            g = 5'b10000;
            tag = "R7";
        end
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog R2: actual %0d cycles expected below %0d", MAX_CYCLES, MAX_CYCLES);
            summary();
            $finish;
        end
    end

    initial begin
        logic [4:0] eg;
        logic       eu;
        string      tag;

        idle_inputs();
        rst = 1'b1;
        // R1: requests and read-modify-write flags present during reset
        @(negedge clk);
        brg_req = 2'b11; brg_rmw = 2'b01; brg_user = 2'b11;
        eng_req = 2'b11; lnk_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(grant == '0, "R1 grant in reset", grant, 0);
        chk(bus_user == 1'b0, "R1 mode in reset", bus_user, 0);
        chk(brg_err == '0, "R1 err in reset", brg_err, 0);
        idle_inputs();
        rst = 1'b0;
        @(negedge clk);
        chk(grant == '0, "R1 grant after reset", grant, 0);

        // Sweep of the full request space
        for (int v = 0; v < 8192; v++) begin
            logic [12:0] vb;
            logic [1:0]  us;
            vb = 13'(v);
            us = vb[1:0] ^ vb[9:8] ^ vb[5:4];
            brg_req = vb[1:0]; brg_rmw = vb[3:2]; brg_user = us;
            eng_req = vb[5:4]; eng_wr = vb[7:6]; eng_prio = vb[11:8];
            lnk_req = vb[12]; xfer_done = 1'b0;
            model(vb[1:0], vb[3:2], us, vb[5:4], vb[7:6], vb[11:8], vb[12], eg, eu, tag);
            @(negedge clk);
            chk(grant == eg, tag, grant, eg);
            chk(bus_user == eu, (eg[1:0] != 0) ? "R8 bridge mode" : "R9 supervisor mode", bus_user, eu);
            chk(brg_err == (vb[1:0] & vb[3:2]), "R10 error response", brg_err, vb[1:0] & vb[3:2]);
            if (eg != '0) begin
                brg_req = 2'b11; brg_rmw = 2'b00; brg_user = ~us;
                eng_req = 2'b11; eng_wr = ~vb[7:6]; lnk_req = 1'b1;
                @(negedge clk);
                chk(grant == eg, "R3 grant held", grant, eg);
                chk(bus_user == eu, "R8 mode held", bus_user, eu);
                idle_inputs();
                xfer_done = 1'b1;
                @(negedge clk);
                chk(grant == '0, "R3 release on done", grant, 0);
                chk(bus_user == 1'b0, "R9 idle mode", bus_user, 0);
                xfer_done = 1'b0;
            end else begin
                idle_inputs();
                @(negedge clk);
                chk(grant == '0, "R10 no grant", grant, 0);
            end
        end

        // R11: engine 0 keeps requesting across moves
        idle_inputs();
        eng_req = 2'b01; eng_wr = 2'b11; eng_prio = 4'b0000;
        @(negedge clk);
        chk(grant == 5'b00100, "R11 engine 0 first move", grant, 5'b00100);
        eng_req = 2'b11; eng_prio = 4'b1100;
        @(negedge clk);
        chk(grant == 5'b00100, "R3 held against higher engine", grant, 5'b00100);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(grant == '0, "R3 idle cycle after done", grant, 0);
        @(negedge clk);
        chk(grant == 5'b01000, "R11 engine 1 wins next move", grant, 5'b01000);
        eng_req = 2'b01;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(grant == '0, "R3 release engine 1", grant, 0);
        @(negedge clk);
        chk(grant == 5'b00100, "R11 engine 0 regains bus", grant, 5'b00100);
        brg_req = 2'b10; brg_user = 2'b10;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        @(negedge clk);
        chk(grant == 5'b00010, "R11 bridge overtakes engine", grant, 5'b00010);
        chk(bus_user == 1'b1, "R8 user mode forwarded", bus_user, 1);

        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule